// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a small status byte that tells software why the chip last left reset. Four reset sources feed it: power-on, the external reset pin, a watchdog timeout, and a brown-out. Each has its own flag. The sources do not treat each other the same way. Power-on wipes every other flag and raises its own. A watchdog flag is dropped as soon as either the pin or the brown-out source becomes active. The pin flag and the brown-out flag ignore each other, and both ignore the watchdog.

Software reads the byte and clears flags by writing ones to them. The write port takes a strobe and data that have already been decoded from the address. All source inputs are level signals that are already synchronous to `clk`. Every update happens on the rising edge, so the read value shows an event one cycle later. Power-on reset also acts as the synchronous reset of the register. Any source that is still active in the first cycle after power-on releases raises its flag at that edge. This is how a supply that ramps straight through the brown-out threshold leaves both the power-on flag and the brown-out flag set.

Top module: `reset_cause_reg`

## Requirements
- R1: Bit 0 is the power-on flag, bit 1 the external pin flag, bit 2 the watchdog flag and bit 3 the brown-out flag. Bits 7:4 always read 0.
- R2: A cycle with `por_i` high makes the next read value exactly 8'h01, whatever the other inputs are.
- R3: With `por_i` low, the power-on flag changes only through a software clear of bit 0. No other source sets or clears it.
- R4: `ext_rst_i` high sets bit 1 at the next edge. Watchdog and brown-out activity leave bit 1 unchanged.
- R5: `wdt_timeout_i` sets bit 2 only when `wdt_rst_en_i` is 1. A timeout with the enable at 0 changes nothing.
- R6: `ext_rst_i` or `bod_rst_i` high clears bit 2 at the next edge. This holds even when a qualified watchdog timeout happens in the same cycle.
- R7: `bod_rst_i` high sets bit 3 at the next edge. Pin and watchdog activity leave bit 3 unchanged.
- R8: A source that is still high in the first cycle after `por_i` falls sets its flag at that edge. The power-on flag stays set. For example, a held brown-out gives 8'h09.
- R9: With `wr_en_i` high, each 1 in `wr_data_i[3:0]` clears that flag at the next edge, and each 0 leaves it unchanged. With `wr_en_i` low the data has no effect.
- R10: When a source sets a flag in the same cycle that software clears it, the flag ends set.
- R11: Writing ones to bits 7:4 leaves them reading 0 and does not disturb bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_i | input | 1 | Power-on reset level, active high; also the register's synchronous reset |
| ext_rst_i | input | 1 | External reset pin level, active high |
| wdt_timeout_i | input | 1 | Watchdog timeout level, active high |
| wdt_rst_en_i | input | 1 | Watchdog mode bit: 1 lets a timeout count as a reset |
| bod_rst_i | input | 1 | Brown-out reset level, active high |
| wr_en_i | input | 1 | Decoded write strobe for this register |
| wr_data_i | input | 8 | Write data; ones clear the matching flags |
| rd_data_o | output | 8 | Registered flag byte |

## Verification
Two kinds of event can meet in one cycle. The first is a hardware source setting a flag while a software write clears that same flag. The second is a qualified watchdog timeout arriving together with a pin or brown-out reset that clears it. The vector table holds rows that drive the strobe with a clearing one at the same time as the matching source, and rows that raise the timeout and a competing source together. The byte read back one edge later must show the set winning over software, and the clearing source winning over the timeout. Rows with only one of the two events run next to these, so each winner is judged against a known single-event result.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 4;

  localparam int BIT_POR = 0;
  localparam int BIT_EXT = 1;
  localparam int BIT_WDT = 2;
  localparam int BIT_BOD = 3;

  localparam logic [REG_W-1:0] POR_VALUE = REG_W'(1) << BIT_POR;
endpackage

// File: rtl/rcc_src_qual.sv
module rcc_src_qual
  import rcc_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         ext_rst_i,
  input  logic         wdt_timeout_i,
  input  logic         wdt_rst_en_i,
  input  logic         bod_rst_i,
  output logic [N-1:0] hw_set_o,
  output logic [N-1:0] hw_clr_o
);
  logic wdt_hit;
  logic wdt_kill;

  always_comb begin
    wdt_kill = ext_rst_i | bod_rst_i;
    wdt_hit  = wdt_timeout_i & wdt_rst_en_i & ~wdt_kill;

    hw_set_o          = '0;
    hw_set_o[BIT_EXT] = ext_rst_i;
    hw_set_o[BIT_WDT] = wdt_hit;
    hw_set_o[BIT_BOD] = bod_rst_i;

    hw_clr_o          = '0;
    hw_clr_o[BIT_WDT] = wdt_kill;
  end
endmodule

// File: rtl/rcc_flag_cell.sv
module rcc_flag_cell #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= INIT;
    else if (hw_set)
      q <= 1'b1;
    else if (hw_clr || sw_clr)
      q <= 1'b0;
  end

  AST_CELL_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_set && sw_clr) |=> q); // R10
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcc_pkg::*;
(
  input  logic             clk,
  input  logic             por_i,
  input  logic             ext_rst_i,
  input  logic             wdt_timeout_i,
  input  logic             wdt_rst_en_i,
  input  logic             bod_rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int RSVD_W = REG_W - NUM_SRC;

  logic [NUM_SRC-1:0] hw_set;
  logic [NUM_SRC-1:0] hw_clr;
  logic [NUM_SRC-1:0] sw_clr;
  logic [NUM_SRC-1:0] flags;

  rcc_src_qual #(.N(NUM_SRC)) u_qual (
    .ext_rst_i     (ext_rst_i),
    .wdt_timeout_i (wdt_timeout_i),
    .wdt_rst_en_i  (wdt_rst_en_i),
    .bod_rst_i     (bod_rst_i),
    .hw_set_o      (hw_set),
    .hw_clr_o      (hw_clr)
  );

  assign sw_clr = wr_en_i ? wr_data_i[NUM_SRC-1:0] : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    rcc_flag_cell #(.INIT(POR_VALUE[i])) u_cell (
      .clk    (clk),
      .rst    (por_i),
      .hw_set (hw_set[i]),
      .hw_clr (hw_clr[i]),
      .sw_clr (sw_clr[i]),
      .q      (flags[i])
    );
  end

  if (RSVD_W > 0) begin : g_rsvd
    assign rd_data_o = {{RSVD_W{1'b0}}, flags};
  end else begin : g_full
    assign rd_data_o = flags;
  end

  AST_POR_VALUE: assert property (@(posedge clk)
    por_i |=> (rd_data_o == POR_VALUE)); // R2
  AST_POR_STICKY: assert property (@(posedge clk) disable iff (por_i)
    !(wr_en_i && wr_data_i[BIT_POR]) |=> (rd_data_o[BIT_POR] == $past(rd_data_o[BIT_POR]))); // R3
  AST_EXT_SET: assert property (@(posedge clk) disable iff (por_i)
    ext_rst_i |=> rd_data_o[BIT_EXT]); // R4
  AST_WDT_GATED: assert property (@(posedge clk) disable iff (por_i)
    (wdt_timeout_i && !wdt_rst_en_i && !wr_en_i) |=> (rd_data_o[BIT_WDT] == $past(rd_data_o[BIT_WDT]) || $past(ext_rst_i || bod_rst_i))); // R5
  AST_WDT_KILLED: assert property (@(posedge clk) disable iff (por_i)
    (ext_rst_i || bod_rst_i) |=> !rd_data_o[BIT_WDT]); // R6
  AST_BOD_SET: assert property (@(posedge clk) disable iff (por_i)
    bod_rst_i |=> rd_data_o[BIT_BOD]); // R7
  AST_W1C: assert property (@(posedge clk) disable iff (por_i)
    (wr_en_i && wr_data_i[BIT_BOD] && !bod_rst_i) |=> !rd_data_o[BIT_BOD]); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (por_i)
    wr_en_i |=> (rd_data_o[REG_W-1:NUM_SRC] == '0)); // R11
endmodule

// File: tb/reset_cause_reg_test.sv
module reset_cause_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // row: {por, ext, wdt, en, bod, wr, data[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {6'b100000, 8'h00, 8'h01},  // 0  R2 power-on
    {6'b000000, 8'h00, 8'h01},  // 1  R3 idle
    {6'b010000, 8'h00, 8'h03},  // 2  R4 pin
    {6'b001000, 8'h00, 8'h03},  // 3  R5 timeout, not enabled
    {6'b001100, 8'h00, 8'h07},  // 4  R5 timeout, enabled
    {6'b000010, 8'h00, 8'h0B},  // 5  R6 R7 brown-out
    {6'b000001, 8'h08, 8'h03},  // 6  R9 clear bit 3
    {6'b001100, 8'h00, 8'h07},  // 7  R5
    {6'b010000, 8'h00, 8'h03},  // 8  R6 pin kills watchdog
    {6'b000001, 8'hF0, 8'h03},  // 9  R11 reserved write
    {6'b000001, 8'h00, 8'h03},  // 10 R9 zeros
    {6'b000000, 8'hFF, 8'h03},  // 11 R9 no strobe
    {6'b000001, 8'h02, 8'h01},  // 12 R9 clear bit 1
    {6'b000010, 8'h00, 8'h09},  // 13 R7
    {6'b010000, 8'h00, 8'h0B},  // 14 R4 R7 independent
    {6'b001100, 8'h00, 8'h0F},  // 15 R5
    {6'b000001, 8'h01, 8'h0E},  // 16 R3 clear power-on flag
    {6'b010000, 8'h00, 8'h0A},  // 17 R6
    {6'b010001, 8'h02, 8'h0A},  // 18 R10 pin beats clear
    {6'b001110, 8'h00, 8'h0A},  // 19 R6 same-cycle timeout loses
    {6'b000011, 8'h0A, 8'h08},  // 20 R10 brown-out beats clear
    {6'b111110, 8'h00, 8'h01}   // 21 R2 power-on over all
  };
  localparam int VREQ [NV] = '{2,3,4,5,5,7,9,5,6,11,9,9,9,7,4,5,3,6,10,6,10,2};

  logic       clk = 1'b0;
  logic       por_i = 1'b1, ext_rst_i = 1'b0, wdt_timeout_i = 1'b0;
  logic       wdt_rst_en_i = 1'b0, bod_rst_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_cause_reg uut (
    .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i), .wdt_timeout_i(wdt_timeout_i),
    .wdt_rst_en_i(wdt_rst_en_i), .bod_rst_i(bod_rst_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
  );

  task automatic drive(input logic [5:0] ctl, input logic [7:0] d);
    {por_i, ext_rst_i, wdt_timeout_i, wdt_rst_en_i, bod_rst_i, wr_en_i} = ctl;
    wr_data_i = d;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (rd_data_o !== exp) begin
      n_bad++;
      $display("FAIL %s: read %h expected %h", req, rd_data_o, exp);
    end
  endtask

  // one cycle: drive at negedge, edge updates, sample at next negedge
  task automatic step(input logic [5:0] ctl, input logic [7:0] d);
    drive(ctl, d);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check("R2 reset state", 8'h01);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21:16], VEC[i][15:8]);
      check($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][7:0]);
    end
    // R8: supply ramp, brown-out outlasts power-on
    step(6'b100010, 8'h00);
    step(6'b100010, 8'h00);
    check("R8 brown-out masked during power-on", 8'h01);
    step(6'b000010, 8'h00);
    check("R8 ramp leaves brown-out set", 8'h09);
    // R8: pin held past power-on release
    step(6'b110000, 8'h00);
    step(6'b010000, 8'h00);
    check("R8 pin held after power-on", 8'h03);
    // R5 R8: timeout held past power-on, not enabled
    step(6'b101000, 8'h00);
    step(6'b001000, 8'h00);
    check("R5 disabled timeout after power-on", 8'h01);
    // R1 R11: all ones written, reserved stays zero
    step(6'b000001, 8'hFF);
    check("R1 R11 full clear", 8'h00);
    step(6'b000000, 8'h00);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d expected %0d", 0, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule